// File: doc/BRIEF.md
# Scaling Step Calculator

This block turns a requested source size and destination size, for one picture direction, into the values a scaler needs. It picks an output size divider: divide by 4, divide by 2 or none. When reducing, it shrinks the source by that same factor before dividing. It then computes the master fixed-point step, which is the reduced source times 2^21 divided by the destination, rounded up. From the master step it derives the luma and chroma step values, using shift rules that depend on the direction and, for vertical chroma, on whether the picture is being enlarged or reduced.

A request is a valid/ready transfer. It is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a division is running, and a request offered during that time simply waits. The result side has no back-pressure. `res_valid` pulses for one cycle, and all result outputs are registers that hold their values until the next result. The division uses a restoring divider that produces one quotient bit per clock, followed by a round-up step. A zero destination is answered at once with an error flag.

Top module: `scale_step_calc`

## Requirements
- R1: After reset:
  - `req_ready` is 1.
  - `res_valid` and `res_err` are 0.
  - `div_code` and every step output are 0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the result appears. A request offered while `req_ready` is low has no effect on the result being computed.
- R3: The divider code depends on `src_size` (src) and `dst_size` (dst), which are unsigned:
  - 2'b10 (divide by 4) when 4*dst <= src.
  - Otherwise 2'b01 (divide by 2) when 2*dst <= src.
  - Otherwise 2'b00 (no divide).
  - Code 2'b11 never appears.
- R4: `master_step` = ceil(e * 2^21 / dst), where the reduced source e is src, floor(src/2) or floor(src/4) for codes 00, 01 and 10.
- R5: For horizontal requests (`vertical`=0):
  - `luma_step` = `chroma_step` = master>>2.
  - `luma_aux` = `chroma_aux` = master>>1.
- R6: For vertical requests (`vertical`=1), `luma_step` = master>>2 and `luma_aux` = (master>>2) + 0x514.
- R7: For vertical requests, the chroma values depend on whether the picture is enlarged or reduced:
  - Enlarging (dst >= src): `chroma_step` = master>>2 and `chroma_aux` = master>>1.
  - Reducing (dst < src): `chroma_step` = master>>3 and `chroma_aux` = master.
- R8: A request with dst = 0 raises `res_valid` with `res_err`=1 one edge after acceptance, and leaves `div_code` and all step outputs unchanged. The next accepted request with a non-zero destination clears `res_err`.
- R9: For a non-zero destination:
  - `res_valid` rises SIZE_W+FRAC_BITS+1 edges after the accepting edge and lasts one cycle.
  - The outputs hold their values afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| src_size | input | SIZE_W | Source size in pixels or lines |
| dst_size | input | SIZE_W | Destination size in pixels or lines |
| vertical | input | 1 | 0 = horizontal rules, 1 = vertical rules |
| res_valid | output | 1 | One-cycle pulse: result registers updated |
| res_err | output | 1 | Last request had a zero destination |
| div_code | output | 2 | Output size divider code |
| master_step | output | SIZE_W+FRAC_BITS | Rounded-up master step |
| luma_step | output | SIZE_W+FRAC_BITS | Luma step value |
| luma_aux | output | SIZE_W+FRAC_BITS | Second luma value |
| chroma_step | output | SIZE_W+FRAC_BITS | Chroma step value |
| chroma_aux | output | SIZE_W+FRAC_BITS | Second chroma value |

## Verification
The bench uses a 6-bit size configuration and tries every pair of source and destination sizes. The direction alternates with the parity of the pair.

The sweep exercises each divider-selection boundary and the enlarge/reduce split, including equal sizes. It also exercises both outcomes of the round-up: exact quotients against those with a remainder.

Zero destinations are mixed into the sweep. This shows that rejected requests leave earlier results untouched and that the error flag clears on the next good request. A request offered while the block is busy shows whether a stray transfer can corrupt an ongoing division.

// File: rtl/scale_pkg.sv
package scale_pkg;
  typedef enum logic [1:0] {
    DIV_NONE = 2'b00,
    DIV_TWO  = 2'b01,
    DIV_FOUR = 2'b10
  } div_code_e;

  localparam int unsigned AUX_OFFSET = 32'h514;
endpackage

// File: rtl/scale_plan.sv
module scale_plan
  import scale_pkg::*;
#(
  parameter int SIZE_W = 16
) (
  input  logic [SIZE_W-1:0] src,
  input  logic [SIZE_W-1:0] dst,
  output div_code_e         code,
  output logic [SIZE_W-1:0] eff_src,
  output logic              reducing
);
  localparam int CW = SIZE_W + 2;

  logic [CW-1:0] src_w, dst_x2, dst_x4;

  always_comb begin
    src_w  = CW'(src);
    dst_x2 = CW'(dst) << 1;
    dst_x4 = CW'(dst) << 2;
    reducing = (dst < src);
    if (dst_x4 <= src_w) begin
      code    = DIV_FOUR;
      eff_src = src >> 2;
    end else if (dst_x2 <= src_w) begin
      code    = DIV_TWO;
      eff_src = src >> 1;
    end else begin
      code    = DIV_NONE;
      eff_src = src;
    end
  end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int NUM_W = 37,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quotient,
  output logic             rem_nz
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   trial;
  logic             fits;
  logic [DEN_W-1:0] rem_next;

  always_comb begin
    trial    = {rem_q, quo_q[NUM_W-1]};
    fits     = (trial >= {1'b0, den_q});
    rem_next = fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        quo_q <= num;
        rem_q <= '0;
        den_q <= den;
        cnt_q <= CNT_W'(NUM_W);
        busy  <= 1'b1;
      end else if (busy) begin
        quo_q <= {quo_q[NUM_W-2:0], fits};
        rem_q <= rem_next;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;
  assign rem_nz   = (rem_q != '0);

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_q < den_q)); // R4
endmodule

// File: rtl/step_deriver.sv
module step_deriver
  import scale_pkg::*;
#(
  parameter int STEP_W = 37
) (
  input  logic [STEP_W-1:0] master,
  input  logic              vertical,
  input  logic              reducing,
  output logic [STEP_W-1:0] luma_step,
  output logic [STEP_W-1:0] luma_aux,
  output logic [STEP_W-1:0] chroma_step,
  output logic [STEP_W-1:0] chroma_aux
);
  logic [STEP_W-1:0] sh1, sh2, sh3;

  always_comb begin
    sh1 = master >> 1;
    sh2 = master >> 2;
    sh3 = master >> 3;
    luma_step = sh2;
    if (!vertical) begin
      luma_aux    = sh1;
      chroma_step = sh2;
      chroma_aux  = sh1;
    end else begin
      luma_aux    = sh2 + STEP_W'(AUX_OFFSET);
      chroma_step = reducing ? sh3 : sh2;
      chroma_aux  = reducing ? master : sh1;
    end
  end
endmodule

// File: rtl/scale_step_calc.sv
module scale_step_calc
  import scale_pkg::*;
#(
  parameter int SIZE_W    = 16,
  parameter int FRAC_BITS = 21
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [SIZE_W-1:0]           src_size,
  input  logic [SIZE_W-1:0]           dst_size,
  input  logic                        vertical,
  output logic                        res_valid,
  output logic                        res_err,
  output logic [1:0]                  div_code,
  output logic [SIZE_W+FRAC_BITS-1:0] master_step,
  output logic [SIZE_W+FRAC_BITS-1:0] luma_step,
  output logic [SIZE_W+FRAC_BITS-1:0] luma_aux,
  output logic [SIZE_W+FRAC_BITS-1:0] chroma_step,
  output logic [SIZE_W+FRAC_BITS-1:0] chroma_aux
);
  localparam int STEP_W = SIZE_W + FRAC_BITS;

  div_code_e         plan_code, code_q;
  logic [SIZE_W-1:0] eff_src;
  logic              plan_red, red_q, vert_q, run_q;
  logic              accept, bad_den;
  logic              dv_busy, dv_done, dv_rem_nz;
  logic [STEP_W-1:0] dv_quo, master_nx;
  logic [STEP_W-1:0] ls_nx, la_nx, cs_nx, ca_nx;

  assign req_ready = !run_q;
  assign accept    = req_valid && req_ready;
  assign bad_den   = (dst_size == '0);

  scale_plan #(.SIZE_W(SIZE_W)) u_plan (
    .src(src_size), .dst(dst_size),
    .code(plan_code), .eff_src(eff_src), .reducing(plan_red)
  );

  restoring_divider #(.NUM_W(STEP_W), .DEN_W(SIZE_W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .start(accept && !bad_den),
    .num({eff_src, {FRAC_BITS{1'b0}}}),
    .den(dst_size),
    .busy(dv_busy), .done(dv_done),
    .quotient(dv_quo), .rem_nz(dv_rem_nz)
  );

  assign master_nx = dv_quo + STEP_W'(dv_rem_nz);

  step_deriver #(.STEP_W(STEP_W)) u_derive (
    .master(master_nx), .vertical(vert_q), .reducing(red_q),
    .luma_step(ls_nx), .luma_aux(la_nx),
    .chroma_step(cs_nx), .chroma_aux(ca_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      code_q      <= DIV_NONE;
      red_q       <= 1'b0;
      vert_q      <= 1'b0;
      res_valid   <= 1'b0;
      res_err     <= 1'b0;
      div_code    <= 2'b00;
      master_step <= '0;
      luma_step   <= '0;
      luma_aux    <= '0;
      chroma_step <= '0;
      chroma_aux  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (accept) begin
        if (bad_den) begin
          res_valid <= 1'b1;
          res_err   <= 1'b1;
        end else begin
          run_q  <= 1'b1;
          code_q <= plan_code;
          red_q  <= plan_red;
          vert_q <= vertical;
        end
      end
      if (run_q && dv_done) begin
        run_q       <= 1'b0;
        res_valid   <= 1'b1;
        res_err     <= 1'b0;
        div_code    <= code_q;
        master_step <= master_nx;
        luma_step   <= ls_nx;
        luma_aux    <= la_nx;
        chroma_step <= cs_nx;
        chroma_aux  <= ca_nx;
      end
    end
  end

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dv_busy |-> !req_ready); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    div_code != 2'b11); // R3
  AST_ERR_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> ($stable(master_step) && $stable(div_code)
                                && $stable(chroma_aux))); // R8
  AST_VERT_LUMA_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err && vert_q) |->
      (luma_aux == luma_step + STEP_W'(AUX_OFFSET))); // R6
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |=> !res_valid || res_err); // R9
endmodule

// File: tb/test_scale_step_calc.sv
module test_scale_step_calc;
  localparam int SW = 6;
  localparam int FB = 21;
  localparam int STW = SW + FB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, vertical = 1'b0;
  logic [SW-1:0] src_size = '0, dst_size = '0;
  logic req_ready, res_valid, res_err;
  logic [1:0] div_code;
  logic [STW-1:0] master_step, luma_step, luma_aux, chroma_step, chroma_aux;

  int tests = 0, fails = 0;
  bit finished = 0;

  longint e_code = 0, e_m = 0, e_ls = 0, e_la = 0, e_cs = 0, e_ca = 0;

  always #10 clk = ~clk;

  scale_step_calc #(.SIZE_W(SW), .FRAC_BITS(FB)) i_scale_step_calc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .src_size(src_size), .dst_size(dst_size), .vertical(vertical),
    .res_valid(res_valid), .res_err(res_err), .div_code(div_code),
    .master_step(master_step), .luma_step(luma_step), .luma_aux(luma_aux),
    .chroma_step(chroma_step), .chroma_aux(chroma_aux)
  );

  task automatic chk(input string rq, input longint got, input longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", rq, got, exp);
    end
  endtask

  task automatic model(input int s, input int d, input bit v);
    longint eff, num;
    if (d == 0) return;
    if (4 * d <= s) begin e_code = 2; eff = s / 4; end
    else if (2 * d <= s) begin e_code = 1; eff = s / 2; end
    else begin e_code = 0; eff = s; end
    num = eff << FB;
    e_m = (num + d - 1) / d;
    e_ls = e_m >> 2;
    if (!v) begin
      e_la = e_m >> 1; e_cs = e_m >> 2; e_ca = e_m >> 1;
    end else begin
      e_la = (e_m >> 2) + 64'h514;
      if (d < s) begin e_cs = e_m >> 3; e_ca = e_m; end
      else begin e_cs = e_m >> 2; e_ca = e_m >> 1; end
    end
  endtask

  task automatic compare_outputs(input int d, input bit v);
    chk("R3 div_code", div_code, e_code);
    chk("R4 master_step", master_step, e_m);
    chk(v ? "R6 luma_step" : "R5 luma_step", luma_step, e_ls);
    chk(v ? "R6 luma_aux" : "R5 luma_aux", luma_aux, e_la);
    chk(v ? "R7 chroma_step" : "R5 chroma_step", chroma_step, e_cs);
    chk(v ? "R7 chroma_aux" : "R5 chroma_aux", chroma_aux, e_ca);
    chk("R8 res_err", res_err, (d == 0) ? 1 : 0);
  endtask

  // one request; optionally offers a stray request while busy (R2)
  task automatic run_req(input int s, input int d, input bit v, input bit stray);
    int cnt;
    @(negedge clk);
    req_valid = 1'b1; src_size = SW'(s); dst_size = SW'(d); vertical = v;
    @(negedge clk);
    req_valid = 1'b0;
    if (d != 0) chk("R2 ready low after accept", req_ready, 0);
    cnt = 0;
    while (!res_valid && cnt < 200) begin
      if (stray && cnt == 3) begin
        req_valid = 1'b1; src_size = SW'(s ^ 7); dst_size = SW'(d ^ 5);
        vertical = ~v;
      end
      @(posedge clk);
      cnt++;
      @(negedge clk);
      req_valid = 1'b0;
    end
    model(s, d, v);
    chk("R9 latency", cnt, (d == 0) ? 0 : STW + 1);
    compare_outputs(d, v);
    @(negedge clk);
    chk("R9 res_valid one cycle", res_valid, 0);
    compare_outputs(d, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 res_err", res_err, 0);
    chk("R1 div_code", div_code, 0);
    chk("R1 master_step", master_step, 0);
    chk("R1 luma_aux", luma_aux, 0);
    chk("R1 chroma_aux", chroma_aux, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_req(5, 0, 1'b0, 1'b0);        // R8 error straight from reset
    run_req(40, 10, 1'b1, 1'b1);      // R2 stray request while busy
    run_req(63, 0, 1'b1, 1'b0);       // R8 error keeps previous values
    for (int s = 0; s < (1 << SW); s++)
      for (int d = 0; d < (1 << SW); d++)
        run_req(s, d, bit'((s ^ d) & 1), 1'b0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule